// File: doc/BRIEF.md
# DMA Channel Burst Transfer Sequencer

This block runs a single DMA channel. It moves a frame of elements from a source port to a destination port, and a small channel FIFO sits between the two sides. When the channel starts, the sequencer decides for each side whether that side may move four elements per service or must move one element at a time. The decision uses the port kind, the alignment of the start address, the element indexing and, while the frame runs, the number of elements still to move. Reads and writes use a plain request/acknowledge handshake. One acknowledge moves exactly one element. The request and the element address stay steady until the acknowledge arrives.

A four-element group goes out as a native burst (`rd_burst`/`wr_burst` high on all four beats) when the port can burst. On a peripheral port, or on an external memory that reports no burst support, the same group goes out as four single beats. When the source is misaligned, it falls back to single reads on its own, and the destination still drains the FIFO in bursts once four elements are buffered. Elements left over at the end of a frame move as single accesses. `frame_done` pulses once after the last write of the frame is acknowledged.

Top module: `dma_burst_seq`

## Requirements
- R1: A side works in four-element groups only if its burst-want input is set, `idx_unit` is 1, the low four bits of its start address are zero (a 16-byte boundary), and the two ports are not both external memory. Otherwise every beat on that side has its burst flag low.
- R2: Port codes are 0 and 1 for the two local RAMs, 2 for external memory and 3 for the peripheral. Local RAMs always burst natively. External memory bursts natively only while `ext_burst_ok` is 1. In a native group the burst flag is high on each of its four beats.
- R3: If both sides want bursts and only the source is misaligned, every read is a single beat, and the destination still writes in native bursts.
- R4: If the destination start address is misaligned, every write has `wr_burst` low.
- R5: A group is formed only while at least four elements remain on that side. The last one to three elements of a frame are single beats with the burst flag low.
- R6: With external memory on both sides, neither side bursts, whatever the burst-want inputs are.
- R7: A side on the peripheral port, or on external memory with `ext_burst_ok` low, that qualifies for groups moves each group as four single beats with the burst flag low.
- R8: `elem_size` 0, 1 and 2 select 1, 2 and 4 bytes (3 acts as 4). Each side's address starts at its start address and advances by the element size after every acknowledged element. An unacknowledged request keeps its request and address stable.
- R9: Write data reproduces the read data in the same order, with no element lost, repeated or added. Exactly `elem_count` reads and `elem_count` writes are made.
- R10: The FIFO holds DEPTH (at least 8) elements. It never holds more than DEPTH or is read while empty. A read access starts only when the FIFO has room for its whole length, and a write access starts only when the FIFO holds its whole length.
- R11: `frame_done` is high for exactly one cycle, in the cycle after the final write acknowledge. A `start` with `elem_count` zero, or one given while a frame runs, is ignored.
- R12: Reset (`rst_n` low) drops both requests and `frame_done`, empties the FIFO and clears both burst decisions. A frame started after reset runs as if it were the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| start | input | 1 | Begin a frame when idle |
| src_port | input | 2 | Source port kind code |
| dst_port | input | 2 | Destination port kind code |
| src_addr | input | AW | Source start byte address |
| dst_addr | input | AW | Destination start byte address |
| elem_size | input | 2 | Element size code |
| elem_count | input | CW | Elements in the frame |
| idx_unit | input | 1 | Element index equals 1 |
| src_burst_want | input | 1 | Source side asks for bursting |
| dst_burst_want | input | 1 | Destination side asks for bursting |
| ext_burst_ok | input | 1 | External memory target supports bursts |
| rd_req | output | 1 | Source read request |
| rd_addr | output | AW | Address of the current read element |
| rd_burst | output | 1 | Current read beat is part of a native burst |
| rd_ack | input | 1 | Read element accepted, data valid |
| rd_data | input | DW | Read element data |
| wr_req | output | 1 | Destination write request |
| wr_addr | output | AW | Address of the current write element |
| wr_burst | output | 1 | Current write beat is part of a native burst |
| wr_data | output | DW | Write element data |
| wr_ack | input | 1 | Write element accepted |
| frame_done | output | 1 | One-cycle frame completion pulse |

## Verification
The bench builds the block with its defaults: a 16-bit address, a 12-bit count, 32-bit data and an eight-entry FIFO. With only eight entries, the rule that a four-element read waits for room starts to throttle the source as soon as the destination slows down. Random acknowledges then push the FIFO to full and to empty. Frames of 1 to 10 elements cover whole groups, groups followed by tails, and tail-only frames.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;

  typedef enum logic [1:0] {
    PT_LOCAL0 = 2'd0,
    PT_LOCAL1 = 2'd1,
    PT_EXTMEM = 2'd2,
    PT_PERIPH = 2'd3
  } port_kind_e;

  localparam int unsigned GROUP_LEN = 4;

  function automatic logic [2:0] elem_bytes(input logic [1:0] code);
    case (code)
      2'd0:    elem_bytes = 3'd1;
      2'd1:    elem_bytes = 3'd2;
      default: elem_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic port_native_burst(input port_kind_e kind, input logic ext_ok);
    case (kind)
      PT_LOCAL0, PT_LOCAL1: port_native_burst = 1'b1;
      PT_EXTMEM:            port_native_burst = ext_ok;
      default:              port_native_burst = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dma_burst_fifo.sv
module dma_burst_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [DW-1:0]   din,
  input  logic            pop,
  output logic [DW-1:0]   dout,
  output logic [CNTW-1:0] count
);

  logic [DW-1:0]   mem [DEPTH];
  logic [PW-1:0]   wptr_q, wptr_d;
  logic [PW-1:0]   rptr_q, rptr_d;
  logic [CNTW-1:0] cnt_q,  cnt_d;
  logic            ptr_en;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push) wptr_d = wptr_q + PW'(1);
    if (pop)  rptr_d = rptr_q + PW'(1);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CNTW'(1);
      2'b01:   cnt_d = cnt_q - CNTW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  assign ptr_en = push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (ptr_en) begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= din;
  end

  assign dout  = mem[rptr_q];
  assign count = cnt_q;

endmodule

// File: rtl/dma_burst_side.sv
module dma_burst_side #(
  parameter int AW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [CW-1:0] load_cnt,
  input  logic          load_grp_en,
  input  logic          load_native,
  input  logic [2:0]    step,
  input  logic          room,
  input  logic          ack,
  output logic          req,
  output logic [AW-1:0] addr,
  output logic          burst,
  output logic [2:0]    next_len,
  output logic          on_last
);

  logic [AW-1:0] addr_q,  addr_d;
  logic [CW-1:0] rem_q,   rem_d;
  logic [2:0]    beats_q, beats_d;
  logic          req_q,   req_d;
  logic          grp_q,   grp_d;
  logic          en_q,    en_d;
  logic          nat_q,   nat_d;
  logic          hs, begin_acc, upd;

  assign next_len  = (en_q && rem_q >= CW'(4)) ? 3'd4 : 3'd1;
  assign hs        = req_q & ack;
  assign begin_acc = ~req_q & (rem_q != '0) & room;
  assign upd       = load | hs | begin_acc;

  always_comb begin
    addr_d  = addr_q;
    rem_d   = rem_q;
    beats_d = beats_q;
    req_d   = req_q;
    grp_d   = grp_q;
    en_d    = en_q;
    nat_d   = nat_q;
    if (load) begin
      addr_d  = load_addr;
      rem_d   = load_cnt;
      beats_d = 3'd0;
      req_d   = 1'b0;
      grp_d   = 1'b0;
      en_d    = load_grp_en;
      nat_d   = load_native;
    end else if (hs) begin
      addr_d  = addr_q + AW'(step);
      rem_d   = rem_q - CW'(1);
      beats_d = beats_q - 3'd1;
      if (beats_q == 3'd1) req_d = 1'b0;
    end else if (begin_acc) begin
      req_d   = 1'b1;
      beats_d = next_len;
      grp_d   = (next_len == 3'd4);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rem_q   <= '0;
      beats_q <= '0;
      req_q   <= 1'b0;
      grp_q   <= 1'b0;
      en_q    <= 1'b0;
      nat_q   <= 1'b0;
    end else if (upd) begin
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      beats_q <= beats_d;
      req_q   <= req_d;
      grp_q   <= grp_d;
      en_q    <= en_d;
      nat_q   <= nat_d;
    end
  end

  assign req     = req_q;
  assign addr    = addr_q;
  assign burst   = req_q & grp_q & nat_q;
  assign on_last = (rem_q == CW'(1));

endmodule

// File: rtl/dma_burst_seq.sv
module dma_burst_seq
  import dma_burst_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 12,
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    src_port,
  input  logic [1:0]    dst_port,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [1:0]    elem_size,
  input  logic [CW-1:0] elem_count,
  input  logic          idx_unit,
  input  logic          src_burst_want,
  input  logic          dst_burst_want,
  input  logic          ext_burst_ok,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          rd_burst,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic          wr_burst,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ack,
  output logic          frame_done
);

  port_kind_e      src_kind, dst_kind;
  logic            both_ext, load;
  logic            src_grp_ok, dst_grp_ok, src_nat, dst_nat;
  logic [2:0]      step_q, step_d;
  logic            run_q, run_d, done_q, done_d, ctl_en;
  logic [2:0]      src_len, dst_len;
  logic            src_room, dst_room, src_last, dst_last, dst_final;
  logic [CNTW-1:0] fifo_cnt, fifo_free;
  logic            push, pop;

  assign src_kind = port_kind_e'(src_port);
  assign dst_kind = port_kind_e'(dst_port);
  assign both_ext = (src_kind == PT_EXTMEM) && (dst_kind == PT_EXTMEM);
  assign load     = start & ~run_q & (elem_count != '0);

  assign src_grp_ok = src_burst_want & idx_unit & (src_addr[3:0] == 4'h0) & ~both_ext;
  assign dst_grp_ok = dst_burst_want & idx_unit & (dst_addr[3:0] == 4'h0) & ~both_ext;
  assign src_nat    = port_native_burst(src_kind, ext_burst_ok);
  assign dst_nat    = port_native_burst(dst_kind, ext_burst_ok);

  assign push      = rd_req & rd_ack;
  assign pop       = wr_req & wr_ack;
  assign fifo_free = CNTW'(DEPTH) - fifo_cnt;
  assign src_room  = fifo_free >= CNTW'(src_len);
  assign dst_room  = fifo_cnt  >= CNTW'(dst_len);
  assign dst_final = pop & dst_last;

  always_comb begin
    step_d = step_q;
    run_d  = run_q;
    done_d = dst_final;
    if (load) begin
      step_d = elem_bytes(elem_size);
      run_d  = 1'b1;
    end else if (dst_final) begin
      run_d  = 1'b0;
    end
  end

  assign ctl_en = load | dst_final | done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= 3'd1;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (ctl_en) begin
      step_q <= step_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  dma_burst_side #(.AW(AW), .CW(CW)) u_src (
    .clk(clk), .rst_n(rst_n), .load(load),
    .load_addr(src_addr), .load_cnt(elem_count),
    .load_grp_en(src_grp_ok), .load_native(src_nat),
    .step(step_q), .room(src_room), .ack(rd_ack),
    .req(rd_req), .addr(rd_addr), .burst(rd_burst),
    .next_len(src_len), .on_last(src_last)
  );

  dma_burst_side #(.AW(AW), .CW(CW)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(load),
    .load_addr(dst_addr), .load_cnt(elem_count),
    .load_grp_en(dst_grp_ok), .load_native(dst_nat),
    .step(step_q), .room(dst_room), .ack(wr_ack),
    .req(wr_req), .addr(wr_addr), .burst(wr_burst),
    .next_len(dst_len), .on_last(dst_last)
  );

  dma_burst_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push), .din(rd_data),
    .pop(pop), .dout(wr_data),
    .count(fifo_cnt)
  );

  assign frame_done = done_q;

  logic unused_src_last;
  assign unused_src_last = src_last;

endmodule

// File: rtl/dma_burst_seq_chk.sv
module dma_burst_seq_chk #(
  parameter int AW    = 16,
  parameter int DEPTH = 8,
  parameter int CNTW  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req,
  input logic            rd_ack,
  input logic [AW-1:0]   rd_addr,
  input logic            wr_req,
  input logic            wr_ack,
  input logic [AW-1:0]   wr_addr,
  input logic            frame_done,
  input logic [CNTW-1:0] fifo_cnt
);

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNTW'(DEPTH));

  a_r10_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_ack) |-> (fifo_cnt < CNTW'(DEPTH)));

  a_r10_write_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (fifo_cnt != '0));

  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  a_r11_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(wr_req && wr_ack));

  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr)));

endmodule

bind dma_burst_seq dma_burst_seq_chk #(.AW(AW), .DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_req(rd_req), .rd_ack(rd_ack), .rd_addr(rd_addr),
  .wr_req(wr_req), .wr_ack(wr_ack), .wr_addr(wr_addr),
  .frame_done(frame_done), .fifo_cnt(fifo_cnt)
);

// File: tb/tb_dma_burst_seq.sv
`timescale 1ns/1ps
module tb_dma_burst_seq;
  localparam int AW = 16, CW = 12, DW = 32, DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [1:0] src_port, dst_port, elem_size;
  logic [AW-1:0] src_addr, dst_addr;
  logic [CW-1:0] elem_count;
  logic idx_unit, src_burst_want, dst_burst_want, ext_burst_ok;
  logic rd_req, rd_burst, rd_ack, wr_req, wr_burst, wr_ack, frame_done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;

  always #2 clk = ~clk;

  dma_burst_seq #(.AW(AW), .CW(CW), .DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_port(src_port), .dst_port(dst_port),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .elem_size(elem_size), .elem_count(elem_count), .idx_unit(idx_unit),
    .src_burst_want(src_burst_want), .dst_burst_want(dst_burst_want),
    .ext_burst_ok(ext_burst_ok),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_burst(rd_burst),
    .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_burst(wr_burst),
    .wr_data(wr_data), .wr_ack(wr_ack), .frame_done(frame_done)
  );

  int errors = 0, checks = 0;
  int src_rem, dst_rem, src_left, dst_left, step;
  bit src_en, src_nat, dst_en, dst_nat, src_grp, dst_grp;
  bit active = 0, exp_done = 0, done_seen = 0, ack_all = 0;
  logic [AW-1:0] exp_ra, exp_wa;
  logic [DW-1:0] next_val = 32'hA500_0000;
  logic [DW-1:0] data_q[$];
  string rd_tag = "R1", wr_tag = "R1";

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit native(input logic [1:0] p, input bit ok);
    return (p == 2'd0) || (p == 2'd1) || (p == 2'd2 && ok);
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      rd_ack = 1'b0;
      wr_ack = 1'b0;
      exp_done = 0;
    end else begin
      chk(frame_done == exp_done, "R11", "frame_done", frame_done, exp_done);
      if (exp_done && frame_done) done_seen = 1;
      exp_done = 0;
      rd_ack = ack_all ? 1'b1 : ($urandom_range(0, 3) != 0);
      wr_ack = ack_all ? 1'b1 : ($urandom_range(0, 2) != 0);
      rd_data = next_val;
      if (rd_req && rd_ack) begin
        if (!active || src_rem == 0) begin
          chk(0, "R9", "unexpected read", 1, 0);
        end else begin
          if (src_left == 0) begin
            src_grp = src_en && src_rem >= 4;
            src_left = src_grp ? 4 : 1;
          end
          chk(rd_addr == exp_ra, "R8", "rd_addr", rd_addr, exp_ra);
          chk(rd_burst == (src_grp && src_nat), rd_tag, "rd_burst", rd_burst, src_grp && src_nat);
          data_q.push_back(next_val);
          chk(data_q.size() <= DEPTH, "R10", "fifo fill", data_q.size(), DEPTH);
          next_val = next_val + 32'd1;
          exp_ra = exp_ra + AW'(step);
          src_rem--; src_left--;
        end
      end
      if (wr_req && wr_ack) begin
        if (!active || dst_rem == 0 || data_q.size() == 0) begin
          chk(0, "R9", "unexpected write", 1, 0);
        end else begin
          logic [DW-1:0] e;
          if (dst_left == 0) begin
            dst_grp = dst_en && dst_rem >= 4;
            dst_left = dst_grp ? 4 : 1;
          end
          e = data_q.pop_front();
          chk(wr_data == e, "R9", "wr_data", wr_data, e);
          chk(wr_addr == exp_wa, "R8", "wr_addr", wr_addr, exp_wa);
          chk(wr_burst == (dst_grp && dst_nat), wr_tag, "wr_burst", wr_burst, dst_grp && dst_nat);
          exp_wa = exp_wa + AW'(step);
          dst_rem--; dst_left--;
          if (dst_rem == 0) exp_done = 1;
        end
      end
    end
  end

  task automatic launch(input logic [1:0] sp, input logic [1:0] dp,
                        input logic [AW-1:0] sa, input logic [AW-1:0] da,
                        input logic [1:0] es, input int cnt, input bit idx,
                        input bit sbw, input bit dbw, input bit eok);
    bit both;
    @(negedge clk); #1;
    src_port = sp; dst_port = dp; src_addr = sa; dst_addr = da;
    elem_size = es; elem_count = CW'(cnt); idx_unit = idx;
    src_burst_want = sbw; dst_burst_want = dbw; ext_burst_ok = eok;
    step = (es == 2'd0) ? 1 : (es == 2'd1) ? 2 : 4;
    both = (sp == 2'd2) && (dp == 2'd2);
    src_en = sbw && idx && (sa[3:0] == 4'h0) && !both;
    dst_en = dbw && idx && (da[3:0] == 4'h0) && !both;
    src_nat = native(sp, eok);
    dst_nat = native(dp, eok);
    src_rem = cnt; dst_rem = cnt; src_left = 0; dst_left = 0;
    exp_ra = sa; exp_wa = da;
    active = (cnt != 0); done_seen = 0;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_frame(input string tag, input logic [1:0] sp, input logic [1:0] dp,
                           input logic [AW-1:0] sa, input logic [AW-1:0] da,
                           input logic [1:0] es, input int cnt, input bit idx,
                           input bit sbw, input bit dbw, input bit eok);
    int t;
    launch(sp, dp, sa, da, es, cnt, idx, sbw, dbw, eok);
    t = 0;
    while (!done_seen && t < 3000) begin
      @(negedge clk); #1;
      t++;
    end
    chk(done_seen, tag, "frame completed with done pulse", done_seen, 1);
    chk(data_q.size() == 0 && src_rem == 0, tag, "all elements moved", data_q.size(), 0);
    repeat (3) @(negedge clk);
    #1;
    active = 0;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    src_port = 2'd0; dst_port = 2'd0; src_addr = '0; dst_addr = '0;
    elem_size = 2'd0; elem_count = '0; idx_unit = 1'b1;
    src_burst_want = 1'b0; dst_burst_want = 1'b0; ext_burst_ok = 1'b0;
    rd_data = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!rd_req && !wr_req && !frame_done, "R12", "outputs idle in reset",
        {rd_req, wr_req, frame_done}, 0);
    rst_n = 1'b1;

    rd_tag = "R2"; wr_tag = "R5";
    run_frame("R2", 2'd0, 2'd1, 16'h0100, 16'h0200, 2'd2, 10, 1, 1, 1, 0);
    rd_tag = "R3"; wr_tag = "R3";
    run_frame("R3", 2'd1, 2'd0, 16'h0104, 16'h0300, 2'd1, 8, 1, 1, 1, 0);
    rd_tag = "R4"; wr_tag = "R4";
    run_frame("R4", 2'd0, 2'd1, 16'h0400, 16'h0508, 2'd2, 9, 1, 1, 1, 0);
    rd_tag = "R6"; wr_tag = "R6";
    run_frame("R6", 2'd2, 2'd2, 16'h0600, 16'h0700, 2'd2, 8, 1, 1, 1, 1);
    rd_tag = "R7"; wr_tag = "R7";
    run_frame("R7", 2'd3, 2'd2, 16'h0800, 16'h0900, 2'd1, 8, 1, 1, 1, 0);
    ack_all = 1; rd_tag = "R2"; wr_tag = "R8";
    run_frame("R8", 2'd2, 2'd0, 16'h0A00, 16'h0B00, 2'd0, 5, 1, 1, 1, 1);
    ack_all = 0; rd_tag = "R1"; wr_tag = "R1";
    run_frame("R1", 2'd0, 2'd1, 16'h0C00, 16'h0D00, 2'd2, 8, 0, 1, 1, 0);
    rd_tag = "R5"; wr_tag = "R5";
    run_frame("R5", 2'd0, 2'd1, 16'h0E00, 16'h0F00, 2'd3, 3, 1, 1, 1, 0);
    run_frame("R5", 2'd1, 2'd0, 16'h1000, 16'h1100, 2'd2, 1, 1, 1, 1, 0);

    // R11: start with a zero count is ignored
    launch(2'd0, 2'd1, 16'h1200, 16'h1300, 2'd2, 0, 1, 1, 1, 0);
    repeat (10) @(negedge clk);
    #1;
    chk(!done_seen && !rd_req && !wr_req, "R11", "zero count ignored",
        {done_seen, rd_req, wr_req}, 0);

    // R12: reset in mid-frame, then a clean frame
    launch(2'd0, 2'd1, 16'h1400, 16'h1500, 2'd2, 20, 1, 1, 1, 0);
    repeat (12) @(negedge clk);
    #1;
    rst_n = 1'b0;
    active = 0;
    data_q.delete();
    repeat (2) @(negedge clk);
    #1;
    chk(!rd_req && !wr_req && !frame_done, "R12", "mid-frame reset idles",
        {rd_req, wr_req, frame_done}, 0);
    rst_n = 1'b1;
    rd_tag = "R12"; wr_tag = "R12";
    run_frame("R12", 2'd1, 2'd0, 16'h1600, 16'h1700, 2'd2, 8, 1, 1, 1, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule